// File: doc/BRIEF.md
# Signed-Digit Shift-Add Significand Multiplier

This block multiplies two 24-bit normalized significands, each carrying its hidden bit. It is the significand core of a floating-point multiplier. The multiplier operand is rewritten as canonical signed digits, each worth -1, 0 or +1. The block spends one clock per nonzero digit. A +1 digit adds the multiplicand shifted by the digit's weight, and a -1 digit adds the negated multiplicand shifted the same way. Zero digits take no cycle at all. Once the last nonzero digit has been added, a final stage stores the exact 48-bit product, together with a 24-bit significand that is normalized and rounded to nearest-even and a small exponent adjustment.

A request is made by raising `start` while the block is idle. The controller has three states:
- IDLE waits for a request. On `start` it loads the operands and the recoded digits. It then goes to RUN, or straight to FINISH when no digit is nonzero.
- RUN adds one partial product per clock. It goes to FINISH after the last nonzero digit.
- FINISH registers the results, pulses `done` and returns to IDLE.

Top module: `csd_mant_mul`

## Requirements
- R1: When `done` is high, `product` equals the exact unsigned product `mcand * mplier`, taken from the operands sampled with the accepted `start`.
- R2: In the recoded multiplier, no two adjacent digit positions are both nonzero. The count of nonzero digits is the minimum over all signed-digit forms of the value, using the 25 positions 0..24.
- R3: `done` rises exactly k+1 clock edges after the edge that accepts `start`, where k is the number of nonzero recoded digits. No clock is spent on a zero digit.
- R4: The signed running sum, which may go negative partway through, is non-negative and below 2^48 when the controller reaches FINISH.
- R5: `done` is high for one cycle per operation. `product`, `sig_out` and `exp_adj` hold their values until the next completion.
- R6: `busy` is high from the edge that accepts `start` until the edge that raises `done`. A `start` seen while `busy` is high is ignored and does not change the running result.
- R7: If product bit 47 is 1, `sig_out` is built from bits 47:24 and `exp_adj` is 1. Otherwise `sig_out` is built from bits 46:23 and `exp_adj` is 0.
- R8: Rounding is to nearest, ties to even. The guard bit is the bit just below the kept field, and the sticky bit is the OR of all bits below the guard. The kept field is incremented when guard=1 and either sticky=1 or the kept field's LSB is 1.
- R9: If rounding overflows the 24-bit field, `sig_out` becomes 0x800000 and `exp_adj` is one larger than the value R7 gives.
- R10: After reset, `busy`, `done`, `product`, `sig_out` and `exp_adj` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a multiplication; accepted only when idle |
| mcand | input | 24 | Multiplicand significand, hidden bit in bit 23 |
| mplier | input | 24 | Multiplier significand, recoded to signed digits |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | 48 | Exact product of the last completed operation |
| sig_out | output | 24 | Normalized, rounded significand |
| exp_adj | output | 2 | Exponent increment (0, 1 or 2) |

## Verification
Several properties are checked on every clock:
- The digit set being consumed never holds two adjacent nonzero positions.
- Each RUN cycle removes exactly one digit.
- The running sum has no sign or overflow bits once it reaches FINISH.
- `done` is a single-cycle pulse, and a started operation makes the block busy.
- A normalized product always yields a significand with its top bit set and an exponent adjustment of at most 2.

Some behaviours need the bench's scenarios, which compare the outputs against a behavioural model every cycle:
- exact product values and the latency that follows from the minimal digit count;
- ties rounding both up and down;
- the carry out of rounding;
- a second `start` ignored during a run.

// File: rtl/csd_mul_pkg.sv
package csd_mul_pkg;

    parameter int MANT_W = 24;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FINISH
    } mul_state_t;

    typedef struct packed {
        logic nz;
        logic neg;
    } sdigit_t;

endpackage

// File: rtl/csd_recoder.sv
module csd_recoder
    import csd_mul_pkg::*;
#(
    parameter int MW = MANT_W,
    localparam int ND = MW + 1
) (
    input  logic [MW-1:0]         value,
    output sdigit_t [ND-1:0]      digits
);

    logic [MW+1:0] ext;
    assign ext = {2'b00, value};

    // Carry-chain recoding: a digit is nonzero when the bit and the incoming
    // carry differ; it is negative when the next bit up is also set.
    always_comb begin
        logic cy;
        cy = 1'b0;
        for (int i = 0; i < ND; i++) begin
            digits[i].nz  = ext[i] ^ cy;
            digits[i].neg = (ext[i] ^ cy) & ext[i+1];
            cy = (ext[i] & ext[i+1]) | (ext[i] & cy) | (ext[i+1] & cy);
        end
    end

endmodule

// File: rtl/csd_shift_ctrl.sv
module csd_shift_ctrl
    import csd_mul_pkg::*;
#(
    parameter int MW = MANT_W,
    localparam int ND = MW + 1,
    localparam int AW = 2 * MW + 2,
    localparam int IW = $clog2(ND)
) (
    input  logic [MW-1:0]        mcand,
    input  logic [ND-1:0]        mask,
    input  logic [ND-1:0]        sign,
    output logic signed [AW-1:0] pp,
    output logic [ND-1:0]        rest,
    output logic                 last
);

    logic [IW-1:0]        idx;
    logic signed [AW-1:0] pos_ext;
    logic signed [AW-1:0] neg_ext;

    // lowest pending nonzero digit
    always_comb begin
        logic found;
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < ND; i++) begin
            if (mask[i] && !found) begin
                idx   = IW'(i);
                found = 1'b1;
            end
        end
    end

    // two's-complement unit
    assign pos_ext = {{(AW-MW){1'b0}}, mcand};
    assign neg_ext = ~pos_ext + AW'(1);

    assign pp   = (sign[idx] ? neg_ext : pos_ext) <<< idx;
    assign rest = mask & ~(ND'(1) << idx);
    assign last = (rest == '0);

endmodule

// File: rtl/csd_norm_round.sv
module csd_norm_round
    import csd_mul_pkg::*;
#(
    parameter int MW = MANT_W,
    localparam int PW = 2 * MW
) (
    input  logic [PW-1:0] prod,
    output logic [MW-1:0] sig,
    output logic [1:0]    adj
);

    logic          hi;
    logic [MW-1:0] kept;
    logic          guard;
    logic          sticky;
    logic          up;
    logic [MW:0]   sum;

    always_comb begin
        hi = prod[PW-1];
        if (hi) begin
            kept   = prod[PW-1:MW];
            guard  = prod[MW-1];
            sticky = |prod[MW-2:0];
        end else begin
            kept   = prod[PW-2:MW-1];
            guard  = prod[MW-2];
            sticky = |prod[MW-3:0];
        end
        up  = guard & (sticky | kept[0]);
        sum = {1'b0, kept} + (MW+1)'(up);
        if (sum[MW]) begin
            sig = {1'b1, {(MW-1){1'b0}}};
        end else begin
            sig = sum[MW-1:0];
        end
        adj = 2'(hi) + 2'(sum[MW]);
    end

endmodule

// File: rtl/csd_mant_mul.sv
module csd_mant_mul
    import csd_mul_pkg::*;
#(
    parameter int MW = MANT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MW-1:0]     mcand,
    input  logic [MW-1:0]     mplier,
    output logic              busy,
    output logic              done,
    output logic [2*MW-1:0]   product,
    output logic [MW-1:0]     sig_out,
    output logic [1:0]        exp_adj
);

    localparam int ND = MW + 1;
    localparam int PW = 2 * MW;
    localparam int AW = 2 * MW + 2;

    mul_state_t state_q, state_d;

    sdigit_t [ND-1:0]     rec_digits;
    logic [ND-1:0]        rec_nz, rec_neg;
    logic [ND-1:0]        mask_q, sign_q;
    logic [MW-1:0]        a_q;
    logic signed [AW-1:0] acc_q;
    logic signed [AW-1:0] pp;
    logic [ND-1:0]        rest;
    logic                 last;
    logic [MW-1:0]        nr_sig;
    logic [1:0]           nr_adj;

    logic                 done_q;
    logic [PW-1:0]        product_q;
    logic [MW-1:0]        sig_q;
    logic [1:0]           exp_adj_q;

    csd_recoder #(.MW(MW)) u_rec (
        .value  (mplier),
        .digits (rec_digits)
    );

    for (genvar g = 0; g < ND; g++) begin : g_split
        assign rec_nz[g]  = rec_digits[g].nz;
        assign rec_neg[g] = rec_digits[g].neg;
    end

    csd_shift_ctrl #(.MW(MW)) u_sc (
        .mcand (a_q),
        .mask  (mask_q),
        .sign  (sign_q),
        .pp    (pp),
        .rest  (rest),
        .last  (last)
    );

    csd_norm_round #(.MW(MW)) u_nr (
        .prod (acc_q[PW-1:0]),
        .sig  (nr_sig),
        .adj  (nr_adj)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = (rec_nz == '0) ? ST_FINISH : ST_RUN;
            ST_RUN:    if (last)  state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q       <= '0;
            mask_q    <= '0;
            sign_q    <= '0;
            acc_q     <= '0;
            done_q    <= 1'b0;
            product_q <= '0;
            sig_q     <= '0;
            exp_adj_q <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        a_q    <= mcand;
                        mask_q <= rec_nz;
                        sign_q <= rec_neg;
                        acc_q  <= '0;
                    end
                end
                ST_RUN: begin
                    acc_q  <= acc_q + pp;
                    mask_q <= rest;
                end
                ST_FINISH: begin
                    product_q <= acc_q[PW-1:0];
                    sig_q     <= nr_sig;
                    exp_adj_q <= nr_adj;
                    done_q    <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign busy    = (state_q != ST_IDLE);
    assign done    = done_q;
    assign product = product_q;
    assign sig_out = sig_q;
    assign exp_adj = exp_adj_q;

    // R2: canonical form, no adjacent nonzero digits pending
    a_r2_no_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> ((mask_q & (mask_q >> 1)) == '0));

    // R3: each RUN cycle retires exactly one digit
    a_r3_one_digit_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=> ($countones(mask_q) == $past($countones(mask_q)) - 1));

    // R4: final sum non-negative and inside 48 bits
    a_r4_final_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FINISH) |-> (acc_q[AW-1:PW] == '0));

    // R5: completion is a single-cycle pulse
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: an accepted request makes the block busy
    a_r6_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    // R7: a normalized product yields a significand with its top bit set
    a_r7_sig_msb: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (product[PW-1:PW-2] != 2'b00)) |-> sig_out[MW-1]);

    // R9: exponent adjustment never exceeds two
    a_r9_adj_range: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (exp_adj <= 2'd2));

endmodule

// File: tb/csd_mant_mul_tb.sv
module csd_mant_mul_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] mcand = '0;
    logic [23:0] mplier = '0;
    logic        busy, done;
    logic [47:0] product;
    logic [23:0] sig_out;
    logic [1:0]  exp_adj;

    int n_chk = 0;
    int n_fail = 0;
    bit ended = 1'b0;
    int cycles = 0;

    // behavioural model state
    int          m_cnt = 0;
    bit          m_done = 1'b0;
    logic [47:0] m_prod = '0;
    logic [23:0] m_sig = '0;
    logic [1:0]  m_adj = '0;
    longint      pend_p = 0;

    always #5 clk = ~clk;

    csd_mant_mul dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .mcand   (mcand),
        .mplier  (mplier),
        .busy    (busy),
        .done    (done),
        .product (product),
        .sig_out (sig_out),
        .exp_adj (exp_adj)
    );

    // minimal signed-digit weight by repeated halving
    function automatic int sd_weight(input longint v);
        int n = 0;
        while (v != 0) begin
            if (v[0]) begin
                if (v[1]) v = v + 1;
                else       v = v - 1;
                n++;
            end
            v = v >>> 1;
        end
        return n;
    endfunction

    function automatic void golden(input longint p, output logic [23:0] s, output logic [1:0] a);
        int     sh;
        longint q, rem, half;
        if (p[47]) begin sh = 24; a = 2'd1; end
        else       begin sh = 23; a = 2'd0; end
        q    = p >> sh;
        rem  = p & ((longint'(1) << sh) - 1);
        half = longint'(1) << (sh - 1);
        if (rem > half || (rem == half && q[0])) q = q + 1;
        if (q == (longint'(1) << 24)) begin
            q = longint'(1) << 23;
            a = a + 2'd1;
        end
        s = q[23:0];
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // reference model, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt  = 0;
            m_done = 1'b0;
        end else begin
            m_done = 1'b0;
            if (m_cnt > 0) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_done = 1'b1;
                    m_prod = pend_p[47:0];
                    golden(pend_p, m_sig, m_adj);
                end
            end else if (start) begin
                pend_p = longint'(mcand) * longint'(mplier);
                m_cnt  = sd_weight(longint'(mplier)) + 1;
            end
        end
    end

    // comparison on every falling edge
    always @(negedge clk) begin
        if (rst_n && !ended) begin
            chk(busy == (m_cnt > 0), "R6 busy", longint'(busy), longint'(m_cnt > 0));
            chk(done == m_done, "R2 R3 done timing", longint'(done), longint'(m_done));
            chk(product == m_prod, "R1 R4 R5 product", longint'(product), longint'(m_prod));
            chk(sig_out == m_sig, "R7 R8 R9 sig_out", longint'(sig_out), longint'(m_sig));
            chk(exp_adj == m_adj, "R7 R9 exp_adj", longint'(exp_adj), longint'(m_adj));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !ended) begin
            ended = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic launch(input logic [23:0] a, input logic [23:0] b, input bit poke);
        @(negedge clk);
        start  = 1'b1;
        mcand  = a;
        mplier = b;
        @(negedge clk);
        if (poke) begin
            // R6: request while busy must be ignored
            mcand  = ~a | 24'h800000;
            mplier = 24'h955555;
        end else begin
            start = 1'b0;
        end
        @(negedge clk);
        start = 1'b0;
        while (m_cnt != 0) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(busy == 1'b0 && done == 1'b0, "R10 reset flags", longint'({busy, done}), 0);
        chk(product == '0 && sig_out == '0 && exp_adj == '0, "R10 reset data",
            longint'(product), 0);
        rst_n = 1'b1;
        launch(24'h800000, 24'h800000, 1'b0);  // single digit, R7 low half
        launch(24'hFFFFFF, 24'hFFFFFF, 1'b0);  // two digits, R7 high half
        launch(24'hABCDEF, 24'hAAAAAA, 1'b0);  // twelve digits, R3
        launch(24'hC00000, 24'h800001, 1'b0);  // R8 tie with odd LSB rounds up
        launch(24'hC00000, 24'h800003, 1'b0);  // R8 tie with even LSB stays
        launch(24'hFFF800, 24'h800400, 1'b0);  // R9 rounding carry
        launch(24'h800001, 24'hEEEEEE, 1'b1);  // R6 start while busy
        launch(24'h9ABCDE, 24'hBBBBBB, 1'b0);  // R4 negative partial sums
        for (int i = 0; i < 40; i++) begin
            launch(24'($urandom) | 24'h800000, 24'($urandom) | 24'h800000, (i % 7) == 3);
        end
        repeat (3) @(negedge clk);
        ended = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule